// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target device has left stuck. It is what a controller runs when a transfer was cut off and a target is still holding SDA low in the middle of a byte. Both lines are open-drain. The block pulls SCL or SDA low by raising the matching output enable, and releases a line by dropping it. It reads both wires back through two-flop synchronizers and uses only the synchronized values in its decisions.

A one-cycle `recover_i` pulse starts a run. The block first releases SCL and waits for it to read high, in case a target is stretching the clock. If SCL never rises within the poll limit, the run ends with the SCL-stuck flag set.

If SCL is high and SDA is already high, the run ends at once as a success. If SDA is low, the block makes up to a fixed number of attempts. In each attempt it drives SCL low and then issues up to nine clock pulses. It stops pulsing as soon as SDA reads high, and ends the attempt with a STOP condition. Every phase lasts one step, and a step is a parameter counted in system clocks (5 µs for 100 kHz buses). A one-cycle `done_o` pulse marks the end of a run, and the result flags stay valid until the next run starts.

Top module: `bus_unstick`

## Requirements
- R1: After reset, both output enables are 0, `busy_o` and `done_o` are 0, and `ok_o`, `scl_stuck_o` and `sda_stuck_o` are 0.
- R2: A `recover_i` pulse in idle starts a run with both lines released. SCL is sampled at the end of each step for up to SCL_POLLS (10) steps. If SCL is still low at the last poll, the run ends with `scl_stuck_o`=1, `ok_o`=0 and `sda_stuck_o`=0, and SCL is never driven.
- R3: If SDA reads high at the first poll that finds SCL high, the run ends with `ok_o`=1 and SCL is never driven low.
- R4: If SDA is low, an attempt drives SCL low for one step. It then gives up to PULSES (9) clock pulses, each SCL driven low for one step and then released for one step. SDA is checked before each pulse, and pulsing stops as soon as it reads high.
- R5: Each attempt closes with a STOP condition: SCL released, SDA driven low for one step, then SDA released for one step. SDA is never driven while SCL is driven.
- R6: An attempt succeeds when SDA and SCL both read high after its STOP. Success ends the run with `ok_o`=1 and starts no further attempt. A target that releases SDA after N rising SCL edges (N ≤ 27) therefore sees exactly N rising edges and one STOP.
- R7: After ATTEMPTS (3) failed attempts, the run ends with `ok_o`=0. `sda_stuck_o` is set if SDA reads low, and `scl_stuck_o` is set if SCL reads low.
- R8: Every step lasts exactly STEP_CLKS clock cycles. A released SCL phase between two pulses lasts STEP_CLKS cycles, and so does the low phase of every pulse after the first.
- R9: `done_o` is high for exactly one cycle at the end of a run, with `busy_o` low in that cycle. `busy_o` is high from the cycle after the start pulse until `done_o`. The result flags hold their value until the next run starts, and that start clears them.
- R10: A `recover_i` pulse while `busy_o` is high has no effect. The run goes on unchanged and produces a single `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_i | input | 1 | Start pulse for a recovery run |
| scl_i | input | 1 | SCL wire level, asynchronous |
| sda_i | input | 1 | SDA wire level, asynchronous |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Recovery run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | Bus freed, both lines high |
| scl_stuck_o | output | 1 | SCL read low at the end of the run |
| sda_stuck_o | output | 1 | SDA read low at the end of the run |

## Verification
The bench models a target that stretches SCL for a set number of cycles and holds SDA low until it has seen a set number of rising SCL edges. It counts those edges, the STOP conditions and the phase widths.

The release counts 9, 10, 27 and 28 probe the pulse and attempt boundaries:
- A design that skipped the SDA check before a pulse would give more edges than the target needed.
- A design that miscounted pulses or attempts would give the wrong edge total, or would report failure where one more pulse would have freed the bus.

The clock-stretch cases sit just inside and just outside the tenth poll. A poll count that is off by one flips the SCL-stuck verdict.

Start pulses sent in the middle of a run catch a design that restarts while busy, which shows up as a second `done_o` or extra edges.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_SCL,
    ST_HOLD_LOW,
    ST_PULSE_LOW,
    ST_PULSE_HIGH,
    ST_STOP_LOW,
    ST_STOP_HIGH
  } rec_state_t;

  typedef struct packed {
    logic ok;
    logic scl_stuck;
    logic sda_stuck;
  } outcome_t;

  // true when index idx is the last of limit items (counted from 0)
  function automatic logic at_last(input int unsigned idx, input int unsigned limit);
    return (idx + 1) >= limit;
  endfunction

  // true when a step counter has reached the end of a step of len clocks
  function automatic logic step_wrap(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) >= len;
  endfunction

  // result flags derived from the final line levels
  function automatic outcome_t judge(input logic scl, input logic sda);
    outcome_t r;
    r.ok        = scl && sda;
    r.scl_stuck = !scl;
    r.sda_stuck = !sda;
    return r;
  endfunction

endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] shift_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= '1;
      else        shift_q <= {shift_q[STAGES-2:0], d[g]};
    end
    assign q[g] = shift_q[STAGES-1];
  end

endmodule

// File: rtl/unstick_timer.sv
module unstick_timer
  import bus_unstick_pkg::*;
#(
  parameter int STEP_CLKS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = run && step_wrap(32'(cnt_q), STEP_CLKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/unstick_ctrl.sv
module unstick_ctrl
  import bus_unstick_pkg::*;
#(
  parameter int SCL_POLLS = 10,
  parameter int ATTEMPTS  = 3,
  parameter int PULSES    = 9,
  localparam int NW = $clog2(PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          recover,
  input  logic          tick,
  input  logic          scl_s,
  input  logic          sda_s,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          launch,
  output logic          done,
  output logic          ok,
  output logic          scl_stuck,
  output logic          sda_stuck,
  output logic [NW-1:0] pulse_idx
);

  localparam int PW = $clog2(SCL_POLLS + 1);
  localparam int AW = $clog2(ATTEMPTS + 1);

  rec_state_t    st_q;
  logic [PW-1:0] poll_q;
  logic [NW-1:0] pulse_q;
  logic [AW-1:0] att_q;
  logic          done_q;
  outcome_t      res_q;

  assign busy      = (st_q != ST_IDLE);
  assign launch    = !busy && recover;
  assign scl_oe    = (st_q == ST_HOLD_LOW) || (st_q == ST_PULSE_LOW);
  assign sda_oe    = (st_q == ST_STOP_LOW);
  assign done      = done_q;
  assign ok        = res_q.ok;
  assign scl_stuck = res_q.scl_stuck;
  assign sda_stuck = res_q.sda_stuck;
  assign pulse_idx = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      poll_q  <= '0;
      pulse_q <= '0;
      att_q   <= '0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        st_q   <= ST_WAIT_SCL;
        poll_q <= '0;
        res_q  <= '0;
      end else if (tick) begin
        unique case (st_q)
          ST_WAIT_SCL: begin
            if (scl_s) begin
              if (sda_s) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
                res_q  <= judge(1'b1, 1'b1);
              end else begin
                st_q  <= ST_HOLD_LOW;
                att_q <= '0;
              end
            end else if (at_last(32'(poll_q), SCL_POLLS)) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              res_q  <= '{ok: 1'b0, scl_stuck: 1'b1, sda_stuck: 1'b0};
            end else begin
              poll_q <= poll_q + 1'b1;
            end
          end
          ST_HOLD_LOW: begin
            pulse_q <= '0;
            st_q    <= sda_s ? ST_STOP_LOW : ST_PULSE_LOW;
          end
          ST_PULSE_LOW: st_q <= ST_PULSE_HIGH;
          ST_PULSE_HIGH: begin
            pulse_q <= pulse_q + 1'b1;
            if (sda_s || at_last(32'(pulse_q), PULSES)) st_q <= ST_STOP_LOW;
            else                                        st_q <= ST_PULSE_LOW;
          end
          ST_STOP_LOW: st_q <= ST_STOP_HIGH;
          ST_STOP_HIGH: begin
            if ((scl_s && sda_s) || at_last(32'(att_q), ATTEMPTS)) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              res_q  <= judge(scl_s, sda_s);
            end else begin
              att_q <= att_q + 1'b1;
              st_q  <= ST_HOLD_LOW;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/bus_unstick.sv
module bus_unstick #(
  parameter int STEP_CLKS = 500,
  parameter int SCL_POLLS = 10,
  parameter int ATTEMPTS  = 3,
  parameter int PULSES    = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic ok_o,
  output logic scl_stuck_o,
  output logic sda_stuck_o
);

  localparam int NW = $clog2(PULSES + 1);

  logic [1:0]    line_s;
  logic          step_tick;
  logic          launch;
  logic [NW-1:0] pulse_idx;

  unstick_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sda_i, scl_i}),
    .q    (line_s)
  );

  unstick_timer #(.STEP_CLKS(STEP_CLKS)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_o),
    .tick (step_tick)
  );

  unstick_ctrl #(
    .SCL_POLLS(SCL_POLLS),
    .ATTEMPTS (ATTEMPTS),
    .PULSES   (PULSES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .recover  (recover_i),
    .tick     (step_tick),
    .scl_s    (line_s[0]),
    .sda_s    (line_s[1]),
    .scl_oe   (scl_oe_o),
    .sda_oe   (sda_oe_o),
    .busy     (busy_o),
    .launch   (launch),
    .done     (done_o),
    .ok       (ok_o),
    .scl_stuck(scl_stuck_o),
    .sda_stuck(sda_stuck_o),
    .pulse_idx(pulse_idx)
  );

endmodule

// File: rtl/unstick_chk.sv
module unstick_chk #(
  parameter int PULSES = 9,
  localparam int NW = $clog2(PULSES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          recover,
  input logic          launch,
  input logic          busy,
  input logic          done,
  input logic          ok,
  input logic          scl_stuck,
  input logic          sda_stuck,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          tick,
  input logic [NW-1:0] pulse_idx
);

  // R1: an idle block leaves both wires alone
  p_idle_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  // R5: SDA is pulled only while SCL is released
  p_stop_scl_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !scl_oe);

  // R4: the pulse index never runs past the pulse limit
  p_pulse_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(pulse_idx) <= PULSES));

  // R6: a successful run reports no stuck line
  p_ok_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> (!scl_stuck && !sda_stuck));

  // R8: line drive changes only at a step boundary
  p_step_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> ($stable(scl_oe) && $stable(sda_oe)));

  // R9: done lasts one cycle and arrives with busy low
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: flags hold while idle and not restarted
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !recover) |=> $stable({ok, scl_stuck, sda_stuck}));

  // R10: a start request while busy does not launch
  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && recover) |-> !launch);

endmodule

bind bus_unstick unstick_chk #(.PULSES(PULSES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .recover  (recover_i),
  .launch   (launch),
  .busy     (busy_o),
  .done     (done_o),
  .ok       (ok_o),
  .scl_stuck(scl_stuck_o),
  .sda_stuck(sda_stuck_o),
  .scl_oe   (scl_oe_o),
  .sda_oe   (sda_oe_o),
  .tick     (step_tick),
  .pulse_idx(pulse_idx)
);

// File: tb/sim_bus_unstick.sv
`timescale 1ns/1ps
module sim_bus_unstick;

  localparam int STEP = 8;

  typedef struct packed {
    logic [31:0] hold;
    logic [7:0]  k;
    logic        ok;
    logic        scls;
    logic        sdas;
    logic [7:0]  rise;
    logic [1:0]  stops;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{32'd0,     8'd0,  1'b1, 1'b0, 1'b0, 8'd0,  2'd0}, // R3 immediate success
    '{32'd0,     8'd1,  1'b1, 1'b0, 1'b0, 8'd1,  2'd1}, // R4 one pulse
    '{32'd0,     8'd5,  1'b1, 1'b0, 1'b0, 8'd5,  2'd1}, // R4 early stop
    '{32'd0,     8'd9,  1'b1, 1'b0, 1'b0, 8'd9,  2'd1}, // R4 full first attempt
    '{32'd0,     8'd10, 1'b1, 1'b0, 1'b0, 8'd10, 2'd1}, // R6 second attempt
    '{32'd0,     8'd27, 1'b1, 1'b0, 1'b0, 8'd27, 2'd1}, // R6 last attempt
    '{32'd0,     8'd28, 1'b0, 1'b0, 1'b1, 8'd27, 2'd0}, // R7 gives up
    '{32'd30,    8'd3,  1'b1, 1'b0, 1'b0, 8'd3,  2'd1}, // R2 short stretch
    '{32'd76,    8'd2,  1'b1, 1'b0, 1'b0, 8'd2,  2'd1}, // R2 freed before last poll
    '{32'd84,    8'd0,  1'b0, 1'b1, 1'b0, 8'd0,  2'd0}, // R2 freed after last poll
    '{32'hFFFF,  8'd4,  1'b0, 1'b1, 1'b0, 8'd0,  2'd0}  // R2 clock held
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover = 1'b0;
  logic clr = 1'b0;
  logic [31:0] hold = 32'd0;
  logic [7:0]  k_tgt = 8'd0;

  logic scl_oe, sda_oe, busy, done, ok, scl_stuck, sda_stuck;
  logic scl_bus, sda_bus;

  logic [31:0] cyc;
  logic [7:0]  rise_cnt, stop_cnt, done_cnt, min_rel, min_drv, run_len;
  logic        scl_prev, sda_prev, oe_prev, sdaoe_prev, seen;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  assign scl_bus = !scl_oe && !(cyc < hold);
  assign sda_bus = !sda_oe && (rise_cnt >= k_tgt);

  bus_unstick #(.STEP_CLKS(STEP), .SCL_POLLS(10), .ATTEMPTS(3), .PULSES(9)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .recover_i  (recover),
    .scl_i      (scl_bus),
    .sda_i      (sda_bus),
    .scl_oe_o   (scl_oe),
    .sda_oe_o   (sda_oe),
    .busy_o     (busy),
    .done_o     (done),
    .ok_o       (ok),
    .scl_stuck_o(scl_stuck),
    .sda_stuck_o(sda_stuck)
  );

  // target model and bus monitors
  always @(posedge clk) begin
    if (!rst_n)       cyc <= 32'hFFFF_0000;
    else if (recover) cyc <= 32'd0;
    else if (cyc != 32'hFFFF_FFFF) cyc <= cyc + 1;
    scl_prev   <= scl_bus;
    sda_prev   <= sda_bus;
    oe_prev    <= scl_oe;
    sdaoe_prev <= sda_oe;
    if (clr || !rst_n) begin
      rise_cnt <= 8'd0; stop_cnt <= 8'd0; done_cnt <= 8'd0;
      min_rel <= 8'd255; min_drv <= 8'd255; run_len <= 8'd0; seen <= 1'b0;
    end else begin
      if (scl_bus && !scl_prev && oe_prev) rise_cnt <= rise_cnt + 1;
      if (sda_bus && !sda_prev && sdaoe_prev && scl_bus) stop_cnt <= stop_cnt + 1;
      if (done) done_cnt <= done_cnt + 1;
      if (scl_oe != oe_prev) begin
        if (seen) begin
          if (oe_prev) begin if (run_len < min_drv) min_drv <= run_len; end
          else begin if (run_len < min_rel) min_rel <= run_len; end
        end
        seen <= 1'b1;
        run_len <= 8'd1;
      end else if (run_len != 8'd255) begin
        run_len <= run_len + 1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic pulse_recover();
    @(negedge clk) recover = 1'b1;
    @(negedge clk) recover = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 8'd0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (done_cnt == 8'd0) check("R9 run watchdog, done seen", 0, 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 scl_oe", int'(scl_oe), 0);
    check("R1 sda_oe", int'(sda_oe), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 flags", int'({ok, scl_stuck, sda_stuck}), 0);

    for (int i = 0; i < NV; i++) begin
      hold  = VECS[i].hold;
      k_tgt = VECS[i].k;
      clear_mon();
      pulse_recover();
      wait_done();
      check($sformatf("R6 R7 ok vec%0d", i), int'(ok), int'(VECS[i].ok));
      check($sformatf("R2 R7 scl_stuck vec%0d", i), int'(scl_stuck), int'(VECS[i].scls));
      check($sformatf("R7 sda_stuck vec%0d", i), int'(sda_stuck), int'(VECS[i].sdas));
      check($sformatf("R4 rising edges vec%0d", i), int'(rise_cnt), int'(VECS[i].rise));
      check($sformatf("R5 stops vec%0d", i), int'(stop_cnt), int'(VECS[i].stops));
      check($sformatf("R9 done count vec%0d", i), int'(done_cnt), 1);
      if (VECS[i].k == 8'd5 && VECS[i].hold == 32'd0) begin
        check("R8 released phase width", int'(min_rel), STEP);
        check("R8 driven phase width", int'(min_drv), STEP);
      end
    end

    // R10: start pulses during a run are ignored
    hold  = 32'd0;
    k_tgt = 8'd12;
    clear_mon();
    pulse_recover();
    repeat (20) @(negedge clk);
    pulse_recover();
    repeat (80) @(negedge clk);
    pulse_recover();
    repeat (60) @(negedge clk);
    pulse_recover();
    wait_done();
    repeat (60) @(negedge clk);
    check("R10 busy after run", int'(busy), 0);
    check("R10 single done", int'(done_cnt), 1);
    check("R10 rising edges", int'(rise_cnt), 12);
    check("R10 ok", int'(ok), 1);

    // R9: flags hold while idle, then clear at the next start
    repeat (50) @(negedge clk);
    check("R9 ok held", int'(ok), 1);
    hold  = 32'd0;
    k_tgt = 8'd40;
    clear_mon();
    pulse_recover();
    @(negedge clk);
    check("R9 busy during run", int'(busy), 1);
    check("R9 ok cleared at start", int'(ok), 0);
    wait_done();
    check("R7 sda_stuck after give-up", int'(sda_stuck), 1);
    check("R7 rising edges capped", int'(rise_cnt), 27);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule